// File: doc/BRIEF.md
# Clear-on-read interrupt status register

This block collects events from a line framer and delivers them to a host processor. It watches three level signals: the loss-of-alignment status, the transmit-line-open status and the transmit-line-short status. Some status bits are set by edges or changes on these levels. Other bits are set by single-cycle pulses: multiframe start, transmit-pool room and signaling-error threshold. Each event sets one bit of a status register. The host reads that register through a small register port, and the read clears every bit.

A per-bit mask register keeps chosen events away from the interrupt output and from the summary flag. A global visibility control decides what happens to masked events. With visibility off, masked events are dropped. With visibility on, masked events are still recorded, but they stay silent. The signaling-error bit is honoured only while signaling-unit mode is enabled. After it has been raised once, it is raised again every `REPEAT_CYCLES` clock cycles until a valid-frame pulse arrives.

Register accesses take one cycle. Read data appears on `rdata_o` on the clock edge that follows a cycle with `rd_en_i` high.

Top module: `irq_status_unit`

## Requirements
- R1: Reading address 0 returns the status bits (bit 0 alignment regained, bit 1 transmit line changed, bit 2 transmit pool ready, bit 3 multiframe begin, bit 4 signaling error), and the read clears all of them; status resets to 0.
- R2: An event that falls in the same cycle as a status read-clear is kept in the status register after the read.
- R3: Address 1 is the mask register (bit i masks status bit i) and resets to 0x1F. Address 2 is the control register: bit 0 turns on visibility, bit 1 enables signaling-unit mode; it resets to 0.
- R4: With visibility off, an event whose mask bit is set is not recorded.
- R5: With visibility on, a masked event is recorded but never asserts `irq_o` or the summary flag.
- R6: `irq_o` is high while any unmasked status bit is set. Reading address 3 returns this same summary in bit 0.
- R7: Bit 1 sets on a rising edge of `tx_open_i` and on either edge of `tx_short_i`. A falling edge of `tx_open_i` does not set it.
- R8: Bit 0 sets on a falling edge of `lof_i`. It also sets when `sim_active_i` falls while `lof_i` is low. A rising edge of `lof_i` does not set it.
- R9: A pulse on `pool_room_i` sets bit 2, and a pulse on `mf_start_i` sets bit 3.
- R10: A `sig_err_i` pulse sets bit 4 only when signaling-unit mode is on. The bit is then raised again every `REPEAT_CYCLES` cycles until a `frame_ok_i` pulse is seen.
- R11: Writes to address 0 and address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lof_i | input | 1 | Loss-of-frame-alignment level |
| tx_open_i | input | 1 | Transmit line open level |
| tx_short_i | input | 1 | Transmit line short level |
| sim_active_i | input | 1 | Alarm simulation running level |
| mf_start_i | input | 1 | Transmit multiframe start pulse |
| pool_room_i | input | 1 | Transmit FIFO has room pulse |
| sig_err_i | input | 1 | Signaling error threshold pulse |
| frame_ok_i | input | 1 | Valid signaling frame pulse |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A host read-clear of the status register and a new event can land in the same clock cycle. The bench provokes this in two steps. It first leaves a multiframe bit pending. It then raises the pool-room pulse in exactly the cycle that carries the status read strobe. The bench expects the read data to show only the older multiframe bit, and a second read to show only the pool bit. Receiving the same data twice, or losing the pool bit, counts as a failure.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_EV = 5;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    localparam int EV_ALIGN = 0;
    localparam int EV_LINE  = 1;
    localparam int EV_POOL  = 2;
    localparam int EV_MF    = 3;
    localparam int EV_SIG   = 4;

    localparam logic [ADDR_W-1:0] A_STATUS  = 2'd0;
    localparam logic [ADDR_W-1:0] A_MASK    = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL    = 2'd2;
    localparam logic [ADDR_W-1:0] A_SUMMARY = 2'd3;

    typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/irq_event_detect.sv
module irq_event_detect import irq_pkg::*; (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    lof_i,
    input  logic    tx_open_i,
    input  logic    tx_short_i,
    input  logic    sim_active_i,
    input  logic    mf_start_i,
    input  logic    pool_room_i,
    input  logic    sig_fire_i,
    output ev_vec_t ev_o
);
    typedef struct packed {
        logic lof;
        logic open;
        logic short_l;
        logic sim;
        logic primed;
    } det_t;

    det_t q, d;
    logic lof_fell, sim_done, open_rose, short_moved;

    always_comb begin
        d         = q;
        d.lof     = lof_i;
        d.open    = tx_open_i;
        d.short_l = tx_short_i;
        d.sim     = sim_active_i;
        d.primed  = 1'b1;

        lof_fell    = q.primed & q.lof & ~lof_i;
        sim_done    = q.primed & q.sim & ~sim_active_i & ~lof_i;
        open_rose   = q.primed & ~q.open & tx_open_i;
        short_moved = q.primed & (q.short_l ^ tx_short_i);

        ev_o           = '0;
        ev_o[EV_ALIGN] = lof_fell | sim_done;
        ev_o[EV_LINE]  = open_rose | short_moved;
        ev_o[EV_POOL]  = pool_room_i;
        ev_o[EV_MF]    = mf_start_i;
        ev_o[EV_SIG]   = sig_fire_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7: any change of the short status is reported once primed
    a_r7_short_change: assert property (@(posedge clk) disable iff (!rst_n)
        (q.primed && $past(q.primed) && $changed(tx_short_i)) |-> ev_o[EV_LINE]);
    // R8: a falling loss-of-alignment level reports regained alignment
    a_r8_align_regain: assert property (@(posedge clk) disable iff (!rst_n)
        (q.primed && $past(q.primed) && $fell(lof_i)) |-> ev_o[EV_ALIGN]);
endmodule

// File: rtl/irq_repeat_timer.sv
module irq_repeat_timer #(
    parameter int REPEAT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss7_i,
    input  logic sig_err_i,
    input  logic frame_ok_i,
    output logic fire_o
);
    localparam int CNT_W = $clog2(REPEAT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REPEAT_CYCLES - 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t q, d;
    logic wrap;

    always_comb begin
        d    = q;
        wrap = q.armed && (q.cnt == LAST);
        if (!ss7_i) begin
            d.armed = 1'b0;
            d.cnt   = '0;
        end else if (sig_err_i) begin
            d.armed = 1'b1;
            d.cnt   = '0;
        end else if (frame_ok_i) begin
            d.armed = 1'b0;
            d.cnt   = '0;
        end else if (q.armed) begin
            d.cnt = wrap ? '0 : q.cnt + 1'b1;
        end
        fire_o = ss7_i & (sig_err_i | wrap);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10: a valid frame without a new error stops the re-raise
    a_r10_frame_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok_i && !sig_err_i) |=> (!fire_o || sig_err_i));
    // R10: nothing fires outside signaling-unit mode
    a_r10_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ss7_i |-> !fire_o);
endmodule

// File: rtl/irq_status_core.sv
module irq_status_core import irq_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  ev_vec_t           ev_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              ss7_o
);
    typedef struct packed {
        ev_vec_t           status;
        ev_vec_t           mask;
        logic              vis;
        logic              ss7;
        logic [DATA_W-1:0] rdata;
    } reg_t;

    reg_t    q, d;
    ev_vec_t rec;
    logic    rd_status;
    logic    pend;
    logic    unused_wbits;

    assign unused_wbits = ^wdata_i[DATA_W-1:NUM_EV];

    always_comb begin
        d         = q;
        rec       = ev_i & (~q.mask | {NUM_EV{q.vis}});
        rd_status = rd_en_i && (addr_i == A_STATUS);
        pend      = |(q.status & ~q.mask);

        d.status = (rd_status ? '0 : q.status) | rec;

        if (wr_en_i) begin
            case (addr_i)
                A_MASK: d.mask = wdata_i[NUM_EV-1:0];
                A_CTRL: begin
                    d.vis = wdata_i[0];
                    d.ss7 = wdata_i[1];
                end
                default: ;
            endcase
        end

        if (rd_en_i) begin
            case (addr_i)
                A_STATUS:  d.rdata = DATA_W'(q.status);
                A_MASK:    d.rdata = DATA_W'(q.mask);
                A_CTRL:    d.rdata = DATA_W'({q.ss7, q.vis});
                default:   d.rdata = DATA_W'(pend);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.status <= '0;
            q.mask   <= '1;
            q.vis    <= 1'b0;
            q.ss7    <= 1'b0;
            q.rdata  <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata_o = q.rdata;
    assign irq_o   = pend;
    assign ss7_o   = q.ss7;

    // R1: a status read with no new event leaves nothing set
    a_r1_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && rec == '0) |=> (q.status == '0));
    // R2: an event colliding with a read-clear survives it
    a_r2_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |=> ((q.status & $past(rec)) == $past(rec)));
    // R4: with visibility off no masked bit becomes newly set
    a_r4_masked_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        !q.vis |=> ((q.status & ~$past(q.status) & $past(q.mask)) == '0));
    // R5: a quiet interrupt stays quiet unless an unmasked event arrives
    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && ((ev_i & ~q.mask) == '0) && !wr_en_i) |=> !irq_o);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit import irq_pkg::*; #(
    parameter int REPEAT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lof_i,
    input  logic              tx_open_i,
    input  logic              tx_short_i,
    input  logic              sim_active_i,
    input  logic              mf_start_i,
    input  logic              pool_room_i,
    input  logic              sig_err_i,
    input  logic              frame_ok_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    ev_vec_t ev;
    logic    sig_fire;
    logic    ss7;

    irq_repeat_timer #(.REPEAT_CYCLES(REPEAT_CYCLES)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ss7_i      (ss7),
        .sig_err_i  (sig_err_i),
        .frame_ok_i (frame_ok_i),
        .fire_o     (sig_fire)
    );

    irq_event_detect i_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .lof_i        (lof_i),
        .tx_open_i    (tx_open_i),
        .tx_short_i   (tx_short_i),
        .sim_active_i (sim_active_i),
        .mf_start_i   (mf_start_i),
        .pool_room_i  (pool_room_i),
        .sig_fire_i   (sig_fire),
        .ev_o         (ev)
    );

    irq_status_core i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev),
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .wdata_i (wdata_i),
        .rd_en_i (rd_en_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o),
        .ss7_o   (ss7)
    );
endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
    localparam int RPT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lof = 1'b1, tx_open = 1'b0, tx_short = 1'b0, sim_act = 1'b0;
    logic       mf = 1'b0, pool = 1'b0, sig = 1'b0, fok = 1'b0;
    logic [1:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    int         total = 0, fails = 0, cyc = 0;

    always #5 clk = ~clk;

    irq_status_unit #(.REPEAT_CYCLES(RPT)) i_irq_status_unit (
        .clk(clk), .rst_n(rst_n), .lof_i(lof), .tx_open_i(tx_open),
        .tx_short_i(tx_short), .sim_active_i(sim_act), .mf_start_i(mf),
        .pool_room_i(pool), .sig_err_i(sig), .frame_ok_i(fok),
        .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata), .rd_en_i(rd),
        .rdata_o(rdata), .irq_o(irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_write(logic [1:0] a, logic [7:0] v);
        @(negedge clk); addr = a; wdata = v; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; v = rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R6 reset irq", {7'd0, irq}, 8'h00);
        reg_read(2'd1, v); check("R3 mask reset", v, 8'h1F);
        reg_read(2'd2, v); check("R3 ctrl reset", v, 8'h00);
        reg_read(2'd0, v); check("R1 status reset", v, 8'h00);
    endtask

    task automatic t_pulses;
        logic [7:0] v;
        reg_write(2'd1, 8'h00);
        @(negedge clk); pool = 1'b1; @(negedge clk); pool = 1'b0;
        check("R6 irq on pending", {7'd0, irq}, 8'h01);
        reg_read(2'd3, v); check("R6 summary", v, 8'h01);
        @(negedge clk); mf = 1'b1; @(negedge clk); mf = 1'b0;
        reg_read(2'd0, v); check("R9 pool+mf", v, 8'h0C);
        check("R1 irq after clear", {7'd0, irq}, 8'h00);
        reg_read(2'd0, v); check("R1 cleared", v, 8'h00);
    endtask

    task automatic t_collision;
        logic [7:0] v;
        @(negedge clk); mf = 1'b1; @(negedge clk); mf = 1'b0;
        @(negedge clk); addr = 2'd0; rd = 1'b1; pool = 1'b1;
        @(negedge clk); rd = 1'b0; pool = 1'b0; v = rdata;
        check("R2 old data", v, 8'h08);
        reg_read(2'd0, v); check("R2 event kept", v, 8'h04);
    endtask

    task automatic t_line;
        logic [7:0] v;
        @(negedge clk); tx_open = 1'b1; idle(1);
        reg_read(2'd0, v); check("R7 open rise", v, 8'h02);
        @(negedge clk); tx_open = 1'b0; idle(1);
        reg_read(2'd0, v); check("R7 open fall ignored", v, 8'h00);
        @(negedge clk); tx_short = 1'b1; idle(1);
        reg_read(2'd0, v); check("R7 short rise", v, 8'h02);
        @(negedge clk); tx_short = 1'b0; idle(1);
        reg_read(2'd0, v); check("R7 short fall", v, 8'h02);
    endtask

    task automatic t_align;
        logic [7:0] v;
        @(negedge clk); lof = 1'b0; idle(1);
        reg_read(2'd0, v); check("R8 lof fall", v, 8'h01);
        @(negedge clk); sim_act = 1'b1; idle(2);
        @(negedge clk); sim_act = 1'b0; idle(1);
        reg_read(2'd0, v); check("R8 sim end aligned", v, 8'h01);
        @(negedge clk); lof = 1'b1; idle(1);
        reg_read(2'd0, v); check("R8 lof rise ignored", v, 8'h00);
        @(negedge clk); sim_act = 1'b1; idle(2);
        @(negedge clk); sim_act = 1'b0; idle(1);
        reg_read(2'd0, v); check("R8 sim end unaligned", v, 8'h00);
    endtask

    task automatic t_mask;
        logic [7:0] v;
        reg_write(2'd1, 8'h08);
        @(negedge clk); mf = 1'b1; @(negedge clk); mf = 1'b0;
        reg_read(2'd0, v); check("R4 masked dropped", v, 8'h00);
        reg_write(2'd2, 8'h01);
        @(negedge clk); mf = 1'b1; @(negedge clk); mf = 1'b0;
        check("R5 irq quiet", {7'd0, irq}, 8'h00);
        reg_read(2'd3, v); check("R5 summary quiet", v, 8'h00);
        reg_read(2'd0, v); check("R5 masked visible", v, 8'h08);
        @(negedge clk); pool = 1'b1; @(negedge clk); pool = 1'b0;
        check("R6 unmasked irq", {7'd0, irq}, 8'h01);
        reg_read(2'd0, v); check("R6 status", v, 8'h04);
        reg_write(2'd2, 8'h00);
        reg_write(2'd1, 8'h00);
    endtask

    task automatic t_sig;
        logic [7:0] v;
        @(negedge clk); sig = 1'b1; @(negedge clk); sig = 1'b0;
        reg_read(2'd0, v); check("R10 mode off ignored", v, 8'h00);
        reg_write(2'd2, 8'h02);
        @(negedge clk); sig = 1'b1; @(negedge clk); sig = 1'b0;
        reg_read(2'd0, v); check("R10 first raise", v, 8'h10);
        idle(4);
        reg_read(2'd0, v); check("R10 not yet", v, 8'h00);
        idle(RPT);
        reg_read(2'd0, v); check("R10 re-raise", v, 8'h10);
        @(negedge clk); fok = 1'b1; @(negedge clk); fok = 1'b0;
        reg_read(2'd0, v);
        idle(3 * RPT);
        reg_read(2'd0, v); check("R10 stopped", v, 8'h00);
        reg_write(2'd2, 8'h00);
    endtask

    task automatic t_ro;
        logic [7:0] v;
        reg_write(2'd0, 8'h1F);
        reg_read(2'd0, v); check("R11 status write", v, 8'h00);
        reg_write(2'd3, 8'hFF);
        check("R11 summary write irq", {7'd0, irq}, 8'h00);
        reg_read(2'd1, v); check("R11 mask intact", v, 8'h00);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_pulses;
        t_collision;
        t_line;
        t_align;
        t_mask;
        t_sig;
        t_ro;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule